// File: doc/BRIEF.md
# Virtual Tributary Emulation Header Generator

This block builds the 32-bit header word that goes in front of each fixed-size payload fragment when a single virtual tributary is carried over a packet network. For every packet the upstream logic pulses a start strobe and, in the same cycle, presents that packet's status: a remote-defect request, a bandwidth-saving request, the negative and positive pointer-justification events that belong to the multiframe carried by this packet, an AIS-V condition, and where the V5 byte lies in the fragment (or that the fragment has no V5 byte).

The generator packs these into the header fields, turns the V5 position into a structure pointer that it checks against the tributary size, and adds a 14-bit sequence number. The header is then offered on a valid/ready output. One header is made for each accepted strobe, and a strobe that arrives while an earlier header is still waiting is dropped. Justification flags belong only to the packet whose strobe carried them, so nothing is stretched across later headers.

Top module: `vtce_hdr_gen`

## Requirements
- R1: The header word packs, from bit 31 down: extension flag (bit 31, always 0), remote defect (bit 30), bandwidth-saving (bit 29), N (bit 28), P (bit 27), structure pointer (bits 26:14, 13 bits), sequence number (bits 13:0).
- R2: Bit 30 equals `rdi_req` and bit 29 equals `dba_req` as sampled on the accepted start strobe.
- R3: Without AIS-V, N equals `neg_evt` and P equals `pos_evt` of that packet's strobe only. A following header whose strobe has no event carries N=0 and P=0.
- R4: When `ais_v` is 1, N and P are both 1, whatever the event inputs are.
- R5: When `neg_evt` and `pos_evt` are both 1 without `ais_v`, N and P are both 0, so the header cannot be read as AIS-V.
- R6: When `v5_present` is 1 and `v5_offset` is at most the limit for `vt_kind` (0: 104, 1: 140, 2: 212, 3: 428, which is the multiframe size of 108/144/216/432 bytes less 4), the pointer equals `v5_offset`. Offset 0 denotes the first byte after the header.
- R7: When `v5_present` is 0, or the offset exceeds the limit for `vt_kind`, the pointer is 0x1FF.
- R8: The sequence number is 0 on the first header after reset. It rises by 1 for each accepted strobe and wraps from 16383 to 0.
- R9: A strobe is accepted when `hdr_valid` is 0 or `hdr_ready` is 1. `hdr_valid` is 1 in the cycle after an accepted strobe. While `hdr_valid` is 1 and `hdr_ready` is 0, the word stays unchanged. After a handshake with no new strobe, `hdr_valid` returns to 0.
- R10: A strobe that arrives while `hdr_valid` is 1 and `hdr_ready` is 0 produces no header, leaves the pending word unchanged and uses no sequence number.
- R11: While `rst_n` is 0, `hdr_valid` is 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_start | input | 1 | One-cycle strobe, one per packet |
| rdi_req | input | 1 | Remote defect indication request |
| dba_req | input | 1 | Bandwidth-saving (unequipped/AIS payload) request |
| neg_evt | input | 1 | Negative justification in this packet's multiframe |
| pos_evt | input | 1 | Positive justification in this packet's multiframe |
| ais_v | input | 1 | AIS-V condition on the tributary |
| v5_present | input | 1 | Fragment contains the V5 byte |
| v5_offset | input | 13 | Byte offset of V5 after the header |
| vt_kind | input | 2 | Tributary size: 0 VT1.5, 1 VT2, 2 VT3, 3 VT6 |
| hdr_valid | output | 1 | Header word available |
| hdr_ready | input | 1 | Consumer accepts the header word |
| hdr_word | output | 32 | Packed header word |

## Verification
The flag fields are driven with each event alone, then with both events together, with AIS-V on top of every event combination, and with an event packet followed by a quiet packet. Together these separate a correct AIS-V override, a suppressed conflicting pair and flags that leak into the next header. The pointer is tried at offset 0, exactly at each tributary's limit, one byte past it, and with V5 absent, which exposes off-by-one limits and limits applied to the wrong tributary. The handshake is run with `hdr_ready` held high, toggling, and held low while an extra strobe arrives, which tells a held word from an overwritten one and a skipped sequence number from a consumed one. A run of more than 16384 back-to-back packets covers the sequence wrap.

// File: rtl/vtce_pkg.sv
// Shared types and size rules for the VT emulation header generator.
// Assumes four tributary sizes selected by a 2-bit code.
package vtce_pkg;

    typedef enum logic [1:0] {
        VT_K15 = 2'd0,
        VT_K2  = 2'd1,
        VT_K3  = 2'd2,
        VT_K6  = 2'd3
    } vt_kind_e;

    // Overhead bytes per multiframe that never appear in the payload
    localparam int unsigned VT_OH_BYTES = 4;

    // Bytes one tributary occupies in a multiframe
    function automatic int unsigned mf_bytes(input vt_kind_e k);
        case (k)
            VT_K15:  return 108;
            VT_K2:   return 144;
            VT_K3:   return 216;
            default: return 432;
        endcase
    endfunction

endpackage

// File: rtl/vtce_seq_ctr.sv
// Packet sequence counter. Advances once per accepted packet and wraps
// at its full width. Assumes adv is a single-cycle qualifier.
module vtce_seq_ctr #(
    parameter int unsigned SEQ_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SEQ_W-1:0] seq
);
    localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};

    // Count accepted packets, wrapping from all-ones to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq <= '0;
        else if (adv)
            seq <= (seq == SEQ_MAX) ? '0 : seq + 1'b1;
    end
endmodule

// File: rtl/vtce_ptr_enc.sv
// Structure pointer encoder. Passes the V5 offset through when V5 is
// present and within the limit of the selected tributary size; else it
// returns the absent code. Assumes ABSENT_PTR lies above every limit.
module vtce_ptr_enc
    import vtce_pkg::*;
#(
    parameter int unsigned       PTR_W      = 13,
    parameter logic [PTR_W-1:0]  ABSENT_PTR = 13'h1FF
) (
    input  logic [1:0]       vt_kind,
    input  logic             v5_present,
    input  logic [PTR_W-1:0] v5_offset,
    output logic [PTR_W-1:0] ptr
);
    localparam int unsigned N_KINDS = 4;

    logic [PTR_W-1:0] limit_tab [N_KINDS];

    // One limit per tributary size: multiframe bytes less overhead
    for (genvar gk = 0; gk < N_KINDS; gk++) begin : g_lim
        assign limit_tab[gk] = PTR_W'(mf_bytes(vt_kind_e'(gk)) - VT_OH_BYTES);
    end

    // Select the pointer or the absent code
    always_comb begin
        if (v5_present && (v5_offset <= limit_tab[vt_kind]))
            ptr = v5_offset;
        else
            ptr = ABSENT_PTR;
    end
endmodule

// File: rtl/vtce_flag_enc.sv
// Justification/AIS flag encoder. AIS-V sets both flags; a conflicting
// pair of events without AIS-V sets neither. Purely combinational.
module vtce_flag_enc (
    input  logic neg_evt,
    input  logic pos_evt,
    input  logic ais_v,
    output logic n_flag,
    output logic p_flag
);
    // Derive N and P for one packet
    always_comb begin
        if (ais_v) begin
            n_flag = 1'b1;
            p_flag = 1'b1;
        end else begin
            n_flag = neg_evt & ~pos_evt;
            p_flag = pos_evt & ~neg_evt;
        end
    end
endmodule

// File: rtl/vtce_hdr_gen.sv
// VT emulation header generator top. Captures per-packet status on an
// accepted start strobe and offers the packed header on valid/ready.
// Assumes status inputs are valid in the strobe cycle; a strobe that
// arrives while a header is stalled is dropped.
module vtce_hdr_gen
    import vtce_pkg::*;
#(
    parameter int unsigned SEQ_W = 14,
    parameter int unsigned PTR_W = 13,
    localparam int unsigned HDR_W = 5 + PTR_W + SEQ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             rdi_req,
    input  logic             dba_req,
    input  logic             neg_evt,
    input  logic             pos_evt,
    input  logic             ais_v,
    input  logic             v5_present,
    input  logic [PTR_W-1:0] v5_offset,
    input  logic [1:0]       vt_kind,
    output logic             hdr_valid,
    input  logic             hdr_ready,
    output logic [HDR_W-1:0] hdr_word
);
    localparam logic [PTR_W-1:0] ABSENT_PTR = PTR_W'(9'h1FF);

    logic             accept;
    logic [SEQ_W-1:0] seq;
    logic [PTR_W-1:0] ptr;
    logic             n_flag;
    logic             p_flag;
    logic [HDR_W-1:0] next_word;

    // A strobe is taken when the output slot is empty or draining
    assign accept = pkt_start && (!hdr_valid || hdr_ready);

    vtce_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (accept),
        .seq   (seq)
    );

    vtce_ptr_enc #(.PTR_W(PTR_W), .ABSENT_PTR(ABSENT_PTR)) u_ptr (
        .vt_kind    (vt_kind),
        .v5_present (v5_present),
        .v5_offset  (v5_offset),
        .ptr        (ptr)
    );

    vtce_flag_enc u_flag (
        .neg_evt (neg_evt),
        .pos_evt (pos_evt),
        .ais_v   (ais_v),
        .n_flag  (n_flag),
        .p_flag  (p_flag)
    );

    // Pack fields; extension flag is zero since no extra header follows
    assign next_word = {1'b0, rdi_req, dba_req, n_flag, p_flag, ptr, seq};

    // Output register with valid/ready hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_valid <= 1'b0;
            hdr_word  <= '0;
        end else if (accept) begin
            hdr_valid <= 1'b1;
            hdr_word  <= next_word;
        end else if (hdr_ready) begin
            hdr_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/vtce_hdr_chk.sv
// Protocol and field checker for vtce_hdr_gen, attached by bind.
// Assumes the default 32-bit word layout derived from the parameters.
module vtce_hdr_chk #(
    parameter int unsigned SEQ_W = 14,
    parameter int unsigned PTR_W = 13,
    localparam int unsigned HDR_W = 5 + PTR_W + SEQ_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_start,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic [HDR_W-1:0] hdr_word
);
    localparam int unsigned PTR_LO = SEQ_W;
    localparam logic [PTR_W-1:0] PTR_ABS = PTR_W'(9'h1FF);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(428);

    logic             acc;
    logic             acc_d;
    logic             have_last;
    logic [SEQ_W-1:0] last_seq;
    logic [SEQ_W-1:0] cur_seq;
    logic [PTR_W-1:0] cur_ptr;

    assign acc     = pkt_start && (!hdr_valid || hdr_ready);
    assign cur_seq = hdr_word[SEQ_W-1:0];
    assign cur_ptr = hdr_word[PTR_LO +: PTR_W];

    // Remember the sequence number of the most recent new header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_d     <= 1'b0;
            have_last <= 1'b0;
            last_seq  <= '0;
        end else begin
            acc_d <= acc;
            if (acc_d) begin
                have_last <= 1'b1;
                last_seq  <= cur_seq;
            end
        end
    end

    // R1: extension flag is never set on an offered header
    a_r1_e_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_word[HDR_W-1] == 1'b0));

    // R9: accepted strobe yields a valid header next cycle
    a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> hdr_valid);

    // R9/R10: a stalled header holds its word
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_word)));

    // R8: first header after reset carries sequence zero
    a_r8_seq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_d && !have_last) |-> (cur_seq == '0));

    // R8: each new header follows the previous by one, modulo width
    a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_d && have_last) |-> (cur_seq == SEQ_W'(last_seq + 1'b1)));

    // R7: pointer is either the absent code or within the largest limit
    a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((cur_ptr == PTR_ABS) || (cur_ptr <= PTR_TOP)));

    // R11: reset clears the valid flag
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> !hdr_valid);
endmodule

bind vtce_hdr_gen vtce_hdr_chk #(.SEQ_W(SEQ_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_word  (hdr_word)
);

// File: tb/tb_vtce_hdr_gen.sv
// Scoreboard bench: the driver pushes expected headers, the monitor
// pops and compares them on each handshake.
module tb_vtce_hdr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0;
    logic        rdi_req = 1'b0, dba_req = 1'b0, neg_evt = 1'b0, pos_evt = 1'b0;
    logic        ais_v = 1'b0, v5_present = 1'b0;
    logic [12:0] v5_offset = '0;
    logic [1:0]  vt_kind = '0;
    logic        hdr_valid;
    logic        hdr_ready = 1'b1;
    logic [31:0] hdr_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [13:0] exp_seq = '0;
    logic        toggle_rdy = 1'b0;
    logic        finished = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    vtce_hdr_gen dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
        .rdi_req(rdi_req), .dba_req(dba_req), .neg_evt(neg_evt),
        .pos_evt(pos_evt), .ais_v(ais_v), .v5_present(v5_present),
        .v5_offset(v5_offset), .vt_kind(vt_kind), .hdr_valid(hdr_valid),
        .hdr_ready(hdr_ready), .hdr_word(hdr_word)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected header from the requirements
    function automatic logic [31:0] exp_word(
        input logic r, input logic d, input logic ng, input logic ps,
        input logic ais, input logic pres, input logic [12:0] off,
        input logic [1:0] kind, input logic [13:0] sq);
        int unsigned lim;
        logic n, p;
        logic [12:0] ptr;
        case (kind)
            2'd0: lim = 104;
            2'd1: lim = 140;
            2'd2: lim = 212;
            default: lim = 428;
        endcase
        n = ais | (ng & ~ps);
        p = ais | (ps & ~ng);
        ptr = (pres && (int'(off) <= int'(lim))) ? off : 13'h1FF;
        return {1'b0, r, d, n, p, ptr, sq};
    endfunction

    // Drive one strobe and hold it until it is accepted
    task automatic send(input string tag, input logic r, input logic d,
                        input logic ng, input logic ps, input logic ais,
                        input logic pres, input logic [12:0] off,
                        input logic [1:0] kind);
        @(negedge clk); #1;
        rdi_req = r; dba_req = d; neg_evt = ng; pos_evt = ps; ais_v = ais;
        v5_present = pres; v5_offset = off; vt_kind = kind; pkt_start = 1'b1;
        while (!(!hdr_valid || hdr_ready)) begin
            @(negedge clk); #1;
        end
        exp_q.push_back(exp_word(r, d, ng, ps, ais, pres, off, kind, exp_seq));
        tag_q.push_back(tag);
        exp_seq = exp_seq + 1'b1;
    endtask

    task automatic idle(input int cyc);
        @(negedge clk); #1;
        pkt_start = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        idle(2);
    endtask

    // Ready toggler for back-pressure phases
    always @(negedge clk) if (toggle_rdy) hdr_ready <= ~hdr_ready;

    // Monitor: compare every handshake against the scoreboard
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && hdr_valid && hdr_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected header", hdr_word, '0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(hdr_word === e, t, hdr_word, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check(hdr_valid === 1'b0, "R11 valid low in reset", 32'(hdr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R8: first header, field bits
        send("R8 first seq zero",  0, 0, 0, 0, 0, 1, 13'd0,   2'd0);
        send("R2 rdi bit",         1, 0, 0, 0, 0, 1, 13'd10,  2'd0);
        send("R2 dba bit",         0, 1, 0, 0, 0, 1, 13'd20,  2'd1);
        send("R1 all fields",      1, 1, 0, 1, 0, 1, 13'd77,  2'd2);
        // R3: per-packet justification, no carry-over
        send("R3 neg event",       0, 0, 1, 0, 0, 0, 13'd0,   2'd0);
        send("R3 no carry",        0, 0, 0, 0, 0, 0, 13'd0,   2'd0);
        send("R3 pos event",       0, 0, 0, 1, 0, 0, 13'd0,   2'd1);
        send("R3 no carry pos",    0, 0, 0, 0, 0, 1, 13'd5,   2'd1);
        // R4: AIS-V override
        send("R4 ais alone",       0, 0, 0, 0, 1, 1, 13'd3,   2'd0);
        send("R4 ais with neg",    0, 0, 1, 0, 1, 1, 13'd3,   2'd0);
        send("R4 ais with pos",    1, 0, 0, 1, 1, 0, 13'd3,   2'd3);
        send("R4 ais with both",   0, 1, 1, 1, 1, 0, 13'd3,   2'd2);
        // R5: conflicting events
        send("R5 both events",     0, 0, 1, 1, 0, 1, 13'd9,   2'd0);
        // R6 R7: pointer limits per tributary
        send("R6 limit k0",        0, 0, 0, 0, 0, 1, 13'd104, 2'd0);
        send("R7 over k0",         0, 0, 0, 0, 0, 1, 13'd105, 2'd0);
        send("R6 limit k1",        0, 0, 0, 0, 0, 1, 13'd140, 2'd1);
        send("R7 over k1",         0, 0, 0, 0, 0, 1, 13'd141, 2'd1);
        send("R6 limit k2",        0, 0, 0, 0, 0, 1, 13'd212, 2'd2);
        send("R7 over k2",         0, 0, 0, 0, 0, 1, 13'd213, 2'd2);
        send("R6 limit k3",        0, 0, 0, 0, 0, 1, 13'd428, 2'd3);
        send("R7 over k3",         0, 0, 0, 0, 0, 1, 13'd429, 2'd3);
        send("R7 absent",          0, 0, 0, 0, 0, 0, 13'd50,  2'd3);
        send("R6 zero k3",         0, 0, 0, 0, 0, 1, 13'd0,   2'd3);
        idle(1);
        drain();

        // R9: valid drops after handshake with no new strobe
        check(hdr_valid === 1'b0, "R9 valid drops when idle", 32'(hdr_valid), 0);

        // R9: toggling back-pressure
        toggle_rdy = 1'b1;
        for (int i = 0; i < 12; i++)
            send("R9 toggled ready", i[0], i[1], i[2], 0, 0, 1, 13'(i * 9), 2'(i));
        idle(1);
        drain();
        toggle_rdy = 1'b0;
        @(negedge clk);
        hdr_ready = 1'b1;

        // R9 R10: stall, extra strobe ignored
        hdr_ready = 1'b0;
        send("R9 stalled header", 1, 0, 1, 0, 0, 1, 13'd42, 2'd1);
        idle(3);
        check(hdr_valid === 1'b1 && hdr_word === exp_q[0], "R9 held while stalled",
              hdr_word, exp_q[0]);
        @(negedge clk); #1;
        rdi_req = 0; dba_req = 1; neg_evt = 0; pos_evt = 1; ais_v = 1;
        v5_present = 1; v5_offset = 13'd7; vt_kind = 2'd0; pkt_start = 1'b1;
        @(negedge clk); #1;
        pkt_start = 1'b0;
        repeat (2) @(negedge clk);
        check(hdr_word === exp_q[0], "R10 strobe ignored while stalled",
              hdr_word, exp_q[0]);
        @(negedge clk);
        hdr_ready = 1'b1;
        drain();
        send("R10 seq not consumed", 0, 0, 0, 0, 0, 1, 13'd1, 2'd0);
        idle(1);
        drain();

        // R8: wrap across 16383 -> 0, back to back
        for (int i = 0; i < 16400; i++)
            send("R8 seq wrap", 0, 0, 0, 0, 0, 1, 13'(i % 100), 2'd0);
        idle(1);
        drain();

        check(exp_q.size() == 0, "R9 scoreboard empty", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule